// File: doc/BRIEF.md
# Cartridge ROM Bank Mapper

This block sits between an 8-bit CPU and the memories of a console cartridge. It maps the 64 KiB CPU address space onto three targets: a banked cartridge ROM, a battery-backed save RAM of up to two 16 KiB pages, and an 8 KiB system RAM. For every CPU access it produces a memory select, a physical address and a write enable. It also returns the read byte by steering the data bus of the selected memory back to the CPU.

The CPU address space has four parts. The lowest kilobyte is fixed. The rest of the first 16 KiB, and the second and third 16 KiB windows, each show a ROM bank chosen by software. The third window can show a save-RAM page in place of ROM. The top 16 KiB is system RAM, with the 8 KiB repeated twice. Software programs the mapping by writing to the four highest CPU addresses. Those writes are seen by the mapper and still go into system RAM like any other RAM write. An external input can take the cartridge off the bus.

Top module: `cartMapper`

## Requirements
- R1: After reset the save control selects ROM, window 0 holds bank 0, window 1 holds bank 1 and window 2 holds bank 2, and `saveDirty` is 0.
- R2: `memSel` encodes the target as 0 = none, 1 = ROM, 2 = save RAM, 3 = system RAM. When neither `cpuRd` nor `cpuWr` is high, `memSel` is 0 and `cpuRdData` is 0xFF. Otherwise `cpuRdData` is the data input of the selected memory, or 0xFF when none is selected.
- R3: Addresses 0x0000–0x03FF select ROM at the same address, whatever bank window 0 holds.
- R4: Addresses 0x0400–0x3FFF select ROM at bank0 × 0x4000 + address[13:0]. Addresses 0x4000–0x7FFF select ROM at bank1 × 0x4000 + address[13:0].
- R5: When save RAM is off, addresses 0x8000–0xBFFF select ROM at bank2 × 0x4000 + address[13:0].
- R6: Addresses 0xC000–0xFFFF select system RAM at address[12:0], so 0xE000–0xFFFF repeats 0xC000–0xDFFF.
- R7: A write to 0xFFFD, 0xFFFE or 0xFFFF loads bank0, bank1 or bank2 with the data masked by ROM_BANKS−1. The new value applies from the next clock.
- R8: A write to 0xFFFC sets the save control. With data bit 3 = 0, window 2 shows ROM. With bit 3 = 1, window 2 shows save page 0 if bit 2 = 0, or save page 1 if bit 2 = 1. Save address = (page × 0x4000 + address[13:0]) masked by SAVE_BYTES−1.
- R9: Writes to 0xFFFC–0xFFFF also give `memSel` = 3, `memWe` = 1 and `memAddr` = address[12:0], the same as any other write at or above 0xC000.
- R10: A write to window 2 while save RAM is shown drives `memWe` = 1 and sets `saveDirty`, which then stays at 1 until reset. A write to window 2 while ROM is shown gives `memWe` = 0 and leaves `saveDirty` unchanged.
- R11: While `cartDisable` is high, any access below 0xC000 gives `memSel` = 0, `memWe` = 0 and `cpuRdData` = 0xFF. System RAM accesses are not affected.
- R12: With SAVE_BYTES = 0 the save control is still recorded. Window 2 then selects nothing while save RAM is on: reads return 0xFF, writes give `memWe` = 0, and `saveDirty` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuRd | input | 1 | CPU read strobe |
| cpuWr | input | 1 | CPU write strobe |
| cartDisable | input | 1 | Takes the cartridge off the bus |
| romRdData | input | 8 | Read data from ROM |
| saveRdData | input | 8 | Read data from save RAM |
| ramRdData | input | 8 | Read data from system RAM |
| cpuRdData | output | 8 | Read data returned to the CPU |
| memSel | output | 2 | Selected memory (0 none, 1 ROM, 2 save, 3 system RAM) |
| memAddr | output | PA_W (19) | Physical address within the selected memory |
| memWe | output | 1 | Write enable for the selected memory |
| saveDirty | output | 1 | Sticky flag: save RAM has been written |

## Verification
The bench reads both ends of the fixed kilobyte after window 0 is moved. A design that pages this area would return bank-5 addresses at 0x03FF. It writes bank values above the bank count to show the mask: a design without the mask gives ROM addresses out of range. It checks that a write to a mapper register also writes system RAM at the mirrored offset, and that a write to window 2 while ROM is shown drives no write enable and leaves the modified flag clear. It switches between both save pages and back to ROM, and checks that the modified flag stays set after the switch. A second instance with no save RAM shows that window 2 turns into an empty bus rather than an unmasked save address.

// File: rtl/cartMapperPkg.sv
package cartMapperPkg;
  typedef enum logic [1:0] {SEL_NONE = 2'd0, SEL_ROM = 2'd1, SEL_SAVE = 2'd2, SEL_RAM = 2'd3} memSel_e;
  typedef enum logic [2:0] {RG_FIXED, RG_SLOT0, RG_SLOT1, RG_SLOT2, RG_RAM} region_e;
  typedef struct packed {
    region_e region;
    logic    access;
    logic    write;
    logic    blocked;
    logic    ldCtl;
    logic    ldB0;
    logic    ldB1;
    logic    ldB2;
  } strobes_t;
endpackage

// File: rtl/cartMapperCtrl.sv
module cartMapperCtrl
  import cartMapperPkg::*;
(
  input  logic [15:0] cpuAddr,
  input  logic        cpuRd,
  input  logic        cpuWr,
  input  logic        cartDisable,
  output strobes_t    strb
);
  localparam logic [15:0] REG_BASE = 16'hFFFC;

  logic regHit;
  assign regHit = cpuWr && (cpuAddr[15:2] == REG_BASE[15:2]);

  always_comb begin
    strb = '0;
    unique case (cpuAddr[15:14])
      2'b11:   strb.region = RG_RAM;
      2'b10:   strb.region = RG_SLOT2;
      2'b01:   strb.region = RG_SLOT1;
      default: strb.region = (cpuAddr[13:10] == 4'd0) ? RG_FIXED : RG_SLOT0;
    endcase
    strb.access  = cpuRd || cpuWr;
    strb.write   = cpuWr;
    strb.blocked = cartDisable && (cpuAddr[15:14] != 2'b11);
    strb.ldCtl   = regHit && (cpuAddr[1:0] == 2'd0);
    strb.ldB0    = regHit && (cpuAddr[1:0] == 2'd1);
    strb.ldB1    = regHit && (cpuAddr[1:0] == 2'd2);
    strb.ldB2    = regHit && (cpuAddr[1:0] == 2'd3);
  end
endmodule

// File: rtl/cartMapperPath.sv
module cartMapperPath
  import cartMapperPkg::*;
#(
  parameter int ROM_BANKS  = 32,
  parameter int SAVE_BYTES = 32768,
  parameter int BANK_W     = 5,
  parameter int PA_W       = 19
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strb,
  input  logic [15:0]     cpuAddr,
  input  logic [7:0]      cpuWrData,
  input  logic [7:0]      romRdData,
  input  logic [7:0]      saveRdData,
  input  logic [7:0]      ramRdData,
  output logic [7:0]      cpuRdData,
  output logic [1:0]      memSel,
  output logic [PA_W-1:0] memAddr,
  output logic            memWe,
  output logic            saveDirty
);
  localparam logic [BANK_W-1:0] BANK_MASK = BANK_W'(ROM_BANKS - 1);
  localparam bit                HAS_SAVE  = (SAVE_BYTES > 0);
  localparam logic [14:0]       SAVE_MASK = HAS_SAVE ? 15'(SAVE_BYTES - 1) : 15'd0;

  logic [BANK_W-1:0] bank0Q, bank1Q, bank2Q;
  logic              saveOnQ, savePageQ, dirtyQ;
  memSel_e           sel;
  logic [13:0]       low14;
  logic [14:0]       saveAddr;
  logic              unusedBits;

  assign low14      = cpuAddr[13:0];
  assign saveAddr   = {savePageQ, low14} & SAVE_MASK;
  assign unusedBits = ^{cpuAddr[15:14], cpuWrData};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bank0Q    <= '0;
      bank1Q    <= BANK_W'(1) & BANK_MASK;
      bank2Q    <= BANK_W'(2) & BANK_MASK;
      saveOnQ   <= 1'b0;
      savePageQ <= 1'b0;
      dirtyQ    <= 1'b0;
    end else begin
      if (strb.ldB0) bank0Q <= cpuWrData[BANK_W-1:0] & BANK_MASK;
      if (strb.ldB1) bank1Q <= cpuWrData[BANK_W-1:0] & BANK_MASK;
      if (strb.ldB2) bank2Q <= cpuWrData[BANK_W-1:0] & BANK_MASK;
      if (strb.ldCtl) begin
        saveOnQ   <= cpuWrData[3];
        savePageQ <= cpuWrData[2];
      end
      if (strb.write && sel == SEL_SAVE) dirtyQ <= 1'b1;
    end
  end

  always_comb begin
    sel     = SEL_NONE;
    memAddr = '0;
    unique case (strb.region)
      RG_FIXED: begin sel = SEL_ROM; memAddr = PA_W'(low14); end
      RG_SLOT0: begin sel = SEL_ROM; memAddr = PA_W'({bank0Q, low14}); end
      RG_SLOT1: begin sel = SEL_ROM; memAddr = PA_W'({bank1Q, low14}); end
      RG_SLOT2: begin
        if (!saveOnQ) begin
          sel = SEL_ROM; memAddr = PA_W'({bank2Q, low14});
        end else if (HAS_SAVE) begin
          sel = SEL_SAVE; memAddr = PA_W'(saveAddr);
        end
      end
      default: begin sel = SEL_RAM; memAddr = PA_W'(cpuAddr[12:0]); end
    endcase
    if (!strb.access || strb.blocked) sel = SEL_NONE;
  end

  assign memSel    = sel;
  assign memWe     = strb.write && (sel == SEL_RAM || sel == SEL_SAVE);
  assign saveDirty = dirtyQ;

  always_comb begin
    unique case (sel)
      SEL_ROM:  cpuRdData = romRdData;
      SEL_SAVE: cpuRdData = saveRdData;
      SEL_RAM:  cpuRdData = ramRdData;
      default:  cpuRdData = 8'hFF;
    endcase
  end

  a_r3_fixed_identity: assert property (@(posedge clk) disable iff (!rstN)
    (strb.access && !strb.blocked && cpuAddr[15:10] == 6'd0) |-> (memSel == 2'd1 && memAddr == PA_W'(cpuAddr)));
  a_r6_ram_mirror: assert property (@(posedge clk) disable iff (!rstN)
    (strb.access && cpuAddr[15:14] == 2'b11) |-> (memSel == 2'd3 && memAddr == PA_W'(cpuAddr[12:0])));
  a_r10_rom_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (strb.write && cpuAddr[15:14] == 2'b10 && !saveOnQ) |-> !memWe);
  a_r10_dirty_sticky: assert property (@(posedge clk) disable iff (!rstN)
    saveDirty |=> saveDirty);
  a_r11_disabled_empty: assert property (@(posedge clk) disable iff (!rstN)
    (strb.blocked && strb.access) |-> (cpuRdData == 8'hFF && !memWe));
endmodule

// File: rtl/cartMapper.sv
module cartMapper
  import cartMapperPkg::*;
#(
  parameter int ROM_BANKS  = 32,
  parameter int SAVE_BYTES = 32768,
  localparam int BANK_W    = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
  localparam int ROM_AW    = BANK_W + 14,
  localparam int PA_W      = (ROM_AW > 15) ? ROM_AW : 15
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [15:0]     cpuAddr,
  input  logic [7:0]      cpuWrData,
  input  logic            cpuRd,
  input  logic            cpuWr,
  input  logic            cartDisable,
  input  logic [7:0]      romRdData,
  input  logic [7:0]      saveRdData,
  input  logic [7:0]      ramRdData,
  output logic [7:0]      cpuRdData,
  output logic [1:0]      memSel,
  output logic [PA_W-1:0] memAddr,
  output logic            memWe,
  output logic            saveDirty
);
  strobes_t strb;

  cartMapperCtrl uCtrl (
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cartDisable(cartDisable), .strb(strb)
  );

  cartMapperPath #(
    .ROM_BANKS(ROM_BANKS), .SAVE_BYTES(SAVE_BYTES), .BANK_W(BANK_W), .PA_W(PA_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .romRdData(romRdData), .saveRdData(saveRdData), .ramRdData(ramRdData),
    .cpuRdData(cpuRdData), .memSel(memSel), .memAddr(memAddr), .memWe(memWe),
    .saveDirty(saveDirty)
  );
endmodule

// File: tb/tb_cartMapper.sv
module tb_cartMapper;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ROMD = 8'hA5, SAVED = 8'h5A, RAMD = 8'h3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0, cartDisable = 1'b0;
  logic [7:0]  rdData, nsRdData;
  logic [1:0]  sel, nsSel;
  logic [18:0] addr, nsAddr;
  logic        we, nsWe, dirty, nsDirty;
  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cartMapper dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRd(cpuRd),
    .cpuWr(cpuWr), .cartDisable(cartDisable), .romRdData(ROMD), .saveRdData(SAVED),
    .ramRdData(RAMD), .cpuRdData(rdData), .memSel(sel), .memAddr(addr), .memWe(we),
    .saveDirty(dirty)
  );

  cartMapper #(.SAVE_BYTES(0)) dutNoSave (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRd(cpuRd),
    .cpuWr(cpuWr), .cartDisable(cartDisable), .romRdData(ROMD), .saveRdData(SAVED),
    .ramRdData(RAMD), .cpuRdData(nsRdData), .memSel(nsSel), .memAddr(nsAddr), .memWe(nsWe),
    .saveDirty(nsDirty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic rd, input logic wr, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRd = rd; cpuWr = wr; cpuWrData = d;
    #1;
  endtask

  task automatic readAt(input logic [15:0] a, input string tag, input logic [1:0] eSel,
                        input logic [18:0] eAddr, input logic [7:0] eData);
    drive(a, 1'b1, 1'b0, 8'h00);
    chk({tag, " sel"}, 32'(sel), 32'(eSel));
    chk({tag, " addr"}, 32'(addr), 32'(eAddr));
    chk({tag, " data"}, 32'(rdData), 32'(eData));
  endtask

  task automatic writeAt(input logic [15:0] a, input logic [7:0] d);
    drive(a, 1'b0, 1'b1, d);
    @(posedge clk);
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic tReset;
    drive(16'h0000, 1'b0, 1'b0, 8'h00);
    chk("R2 idle sel", 32'(sel), 0);
    chk("R2 idle data", 32'(rdData), 32'hFF);
    chk("R1 dirty", 32'(dirty), 0);
    readAt(16'h4123, "R1 bank1 reset", 2'd1, 19'h04123, ROMD);
    readAt(16'h8005, "R1 bank2 reset", 2'd1, 19'h08005, ROMD);
    readAt(16'h0400, "R1 bank0 reset", 2'd1, 19'h00400, ROMD);
  endtask

  task automatic tFixedAndBank0;
    writeAt(16'hFFFD, 8'd5);
    readAt(16'h03FF, "R3 fixed top", 2'd1, 19'h003FF, ROMD);
    readAt(16'h0000, "R3 fixed base", 2'd1, 19'h00000, ROMD);
    readAt(16'h0400, "R4 slot0 low", 2'd1, 19'h14400, ROMD);
    readAt(16'h3FFF, "R4 slot0 high", 2'd1, 19'h17FFF, ROMD);
  endtask

  task automatic tBankMask;
    writeAt(16'hFFFE, 8'h23);
    readAt(16'h7001, "R7 bank1 masked", 2'd1, 19'h0F001, ROMD);
    writeAt(16'hFFFF, 8'hFF);
    readAt(16'hBFFF, "R7 bank2 masked R5", 2'd1, 19'h7FFFF, ROMD);
  endtask

  task automatic tSysRam;
    readAt(16'hC123, "R6 ram", 2'd3, 19'h00123, RAMD);
    readAt(16'hE123, "R6 ram mirror", 2'd3, 19'h00123, RAMD);
    drive(16'hFFFF, 1'b0, 1'b1, 8'hFF);
    chk("R9 reg write sel", 32'(sel), 3);
    chk("R9 reg write we", 32'(we), 1);
    chk("R9 reg write addr", 32'(addr), 32'h1FFF);
    @(posedge clk);
    @(negedge clk); cpuWr = 1'b0;
  endtask

  task automatic tRomWriteIgnored;
    drive(16'h8000, 1'b0, 1'b1, 8'h77);
    chk("R10 rom write we", 32'(we), 0);
    @(posedge clk);
    @(negedge clk); cpuWr = 1'b0; #1;
    chk("R10 rom write dirty", 32'(dirty), 0);
  endtask

  task automatic tSaveCtl;
    writeAt(16'hFFFC, 8'h08);
    readAt(16'h8010, "R8 page0", 2'd2, 19'h00010, SAVED);
    drive(16'h9000, 1'b0, 1'b1, 8'h11);
    chk("R10 save write we", 32'(we), 1);
    chk("R10 save write addr", 32'(addr), 32'h1000);
    @(posedge clk);
    @(negedge clk); cpuWr = 1'b0; #1;
    chk("R10 dirty set", 32'(dirty), 1);
    writeAt(16'hFFFC, 8'h0C);
    readAt(16'h8010, "R8 page1", 2'd2, 19'h04010, SAVED);
    writeAt(16'hFFFC, 8'h04);
    readAt(16'h8010, "R8 back to rom R5", 2'd1, 19'h7C010, ROMD);
    chk("R10 dirty sticky", 32'(dirty), 1);
  endtask

  task automatic tDisable;
    @(negedge clk); cartDisable = 1'b1;
    readAt(16'h0100, "R11 disabled rom", 2'd0, 19'h00100, 8'hFF);
    readAt(16'hC000, "R11 ram unaffected", 2'd3, 19'h00000, RAMD);
    drive(16'h8000, 1'b0, 1'b1, 8'h00);
    chk("R11 disabled we", 32'(we), 0);
    @(negedge clk); cpuWr = 1'b0; cartDisable = 1'b0;
  endtask

  task automatic tNoSave;
    writeAt(16'hFFFC, 8'h08);
    drive(16'h8000, 1'b1, 1'b0, 8'h00);
    chk("R12 nosave sel", 32'(nsSel), 0);
    chk("R12 nosave data", 32'(nsRdData), 32'hFF);
    drive(16'h8000, 1'b0, 1'b1, 8'h22);
    chk("R12 nosave we", 32'(nsWe), 0);
    @(posedge clk);
    @(negedge clk); cpuWr = 1'b0; #1;
    chk("R12 nosave dirty", 32'(nsDirty), 0);
    writeAt(16'hFFFC, 8'h00);
    drive(16'h8000, 1'b1, 1'b0, 8'h00);
    chk("R12 nosave rom back", 32'(nsSel), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tReset();
    tFixedAndBank0();
    tBankMask();
    tSysRam();
    tRomWriteIgnored();
    tSaveCtl();
    tDisable();
    tNoSave();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule